// File: doc/BRIEF.md
# Free-Running Timer with Overflow Interrupt

This block is a 16-bit up-counter that advances on a count clock derived from the bus clock by a divider. A three-bit field selects the divide ratio. The counter wraps from its all-ones value back to zero. Each wrap sets a sticky overflow flag. When the matching enable bit is set, the flag drives a level interrupt request. The block also puts out a one-cycle strobe in every cycle where the counter is allowed to advance.

Software reaches the block through a small register port with two locations: a control/status byte and the counter value. To preload the counter, software halts it with the halt bit, writes the counter location, and then clears the halt bit. A separate clear bit zeroes the counter at once while it runs. Both a preload and a clear restart the divider, so the next increment comes one full divide period later.

Top module: `freerun_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the control byte reads 0x00, `irq` is low, and counting starts with no further action.
- R2: With divide select n (control bits 2:0, value 0 to 7), the counter rises by one once every 2^(n+1) clock cycles. `cnt_tick` is high for exactly the cycle that ends in each increment.
- R3: An increment from 0xFFFF gives 0x0000, sets the overflow flag (control bit 7), and counting goes on.
- R4: `irq` is high exactly while the overflow flag and the interrupt enable (control bit 6) are both 1.
- R5: Writing 0 to control bit 7 clears the overflow flag, and writing 1 there leaves it unchanged. If a rollover happens in the same cycle as a clearing write, the flag ends up set.
- R6: While the halt bit (control bit 5) is 1, the counter and the divider hold their values and `cnt_tick` stays low. Writing 0 to the halt bit resumes counting.
- R7: A write to the counter location (`addr` = 1) loads `wdata` into the counter in the next cycle, but only when the block is halted. While the counter runs, such a write is ignored.
- R8: Writing 1 to the clear bit (control bit 3) makes the counter read 0x0000 from the next cycle on. The clear bit always reads as 0.
- R9: A clear or a preload restarts the divider. With select n, the first increment after the write comes 2^(n+1) cycles after the cycle of the write (or of the resume, when halted).
- R10: Control bit 4 is reserved. It always reads as 0, whatever was written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| addr | input | 1 | Register select: 0 = control byte, 1 = counter value |
| wdata | input | 16 | Write data (control byte in bits 7:0) |
| rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Level overflow interrupt request |
| cnt_tick | output | 1 | Strobe marking each counter advance |

## Verification
Assertions check several things on every cycle: the counter holds when it has no advance, clear or load; a wrap leaves zero and a set flag; the flag stays sticky unless a clearing write arrives, and a write of 1 cannot set it; an advance strobe never occurs twice in a row or right after a divider restart; no strobe occurs while halted. Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. These scenarios cover the exact divide periods for several select values, a running counter ignoring a data write, the reserved and clear bits reading back as zero, and a clearing write that lands in the same cycle as a rollover.

// File: rtl/frt_pkg.sv
package frt_pkg;
    // control byte field positions (software decodes these)
    localparam int unsigned BIT_FLAG = 7;
    localparam int unsigned BIT_IEN  = 6;
    localparam int unsigned BIT_STOP = 5;
    localparam int unsigned BIT_RSVD = 4;
    localparam int unsigned BIT_CLR  = 3;

    typedef enum logic {
        REG_CTRL  = 1'b0,
        REG_COUNT = 1'b1
    } frt_reg_e;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             tick_o
);
    localparam int PRE_W = 2 ** SEL_W;
    localparam logic [PRE_W:0] ONE_P = 1;
    localparam logic [SEL_W:0] ONE_S = 1;
    localparam logic [PRE_W-1:0] INC = 1;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t   st_d, st_q;
    logic [PRE_W:0] limit_w;

    always_comb begin
        limit_w = (ONE_P << ({1'b0, div_sel_i} + ONE_S)) - ONE_P;
        tick_o  = run_i && ({1'b0, st_q.phase} >= limit_w);
        st_d    = st_q;
        if (restart_i) begin
            st_d.phase = '0;
        end else if (tick_o) begin
            st_d.phase = '0;
        end else if (run_i) begin
            st_d.phase = st_q.phase + INC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: every period is at least two cycles long
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    // R9: a restart always delays the next advance
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] INC = 1;

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = tick_i && (&st_q.value) && !clr_i && !load_i;
        if (clr_i) begin
            st_d.value = '0;
        end else if (load_i) begin
            st_d.value = load_val_i;
        end else if (tick_i) begin
            st_d.value = st_q.value + INC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.value;

    // R3: a wrap leaves the counter at zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_o == '0));
    // R6: without an advance, clear or load the value holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i && !load_i) |=> $stable(count_o));
    // R8: clear zeroes the counter on the next cycle
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));
    // R7: an accepted load lands exactly
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (count_o == $past(load_val_i)));
    // R2: a plain advance adds one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && !load_i && !(&count_o)) |=> (count_o == $past(count_o) + INC));
endmodule

// File: rtl/frt_ctrl.sv
module frt_ctrl #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             flag_w_i,
    input  logic             ien_w_i,
    input  logic             stop_w_i,
    input  logic [SEL_W-1:0] div_w_i,
    input  logic             wrap_i,
    output logic             flag_o,
    output logic             ien_o,
    output logic             stop_o,
    output logic [SEL_W-1:0] div_sel_o
);
    typedef struct packed {
        logic             flag;
        logic             ien;
        logic             stop;
        logic [SEL_W-1:0] div;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.ien  = ien_w_i;
            st_d.stop = stop_w_i;
            st_d.div  = div_w_i;
            if (!flag_w_i) st_d.flag = 1'b0;
        end
        if (wrap_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o    = st_q.flag;
    assign ien_o     = st_q.ien;
    assign stop_o    = st_q.stop;
    assign div_sel_o = st_q.div;

    // R5: the flag stays set until a write of 0 reaches it
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(wr_i && !flag_w_i)) |=> flag_o);
    // R5: rollover beats a clearing write
    p_wrap_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_o);
    // R5: only a rollover can set the flag
    p_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !wrap_i) |=> !flag_o);
endmodule

// File: rtl/freerun_timer.sv
module freerun_timer #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq,
    output logic             cnt_tick
);
    import frt_pkg::*;

    logic             wr_ctrl, wr_cnt, clr, load, restart;
    logic             flag_q, ien_q, stop_q, wrap;
    logic [SEL_W-1:0] div_sel;
    logic [CNT_W-1:0] count;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_cnt  = wr_en && (addr == REG_COUNT);
    assign clr     = wr_ctrl && wdata[BIT_CLR];
    assign load    = wr_cnt && stop_q;
    assign restart = clr || load;

    frt_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_ctrl),
        .flag_w_i  (wdata[BIT_FLAG]),
        .ien_w_i   (wdata[BIT_IEN]),
        .stop_w_i  (wdata[BIT_STOP]),
        .div_w_i   (wdata[SEL_W-1:0]),
        .wrap_i    (wrap),
        .flag_o    (flag_q),
        .ien_o     (ien_q),
        .stop_o    (stop_q),
        .div_sel_o (div_sel)
    );

    frt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (!stop_q),
        .restart_i (restart),
        .div_sel_i (div_sel),
        .tick_o    (cnt_tick)
    );

    frt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (cnt_tick),
        .clr_i      (clr),
        .load_i     (load),
        .load_val_i (wdata),
        .count_o    (count),
        .wrap_o     (wrap)
    );

    always_comb begin
        rdata = '0;
        if (addr == REG_COUNT) begin
            rdata = count;
        end else begin
            rdata[BIT_FLAG]    = flag_q;
            rdata[BIT_IEN]     = ien_q;
            rdata[BIT_STOP]    = stop_q;
            rdata[SEL_W-1:0]   = div_sel;
        end
    end

    assign irq = flag_q && ien_q;

    // R6: no advance strobe while halted
    p_stop_notick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> !cnt_tick);
endmodule

// File: tb/freerun_timer_bench.sv
module freerun_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        addr = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, cnt_tick;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt = 0, m_phase = 0, m_flag = 0, m_ien = 0, m_stop = 0, m_sel = 0;

    always #5 clk = ~clk;

    freerun_timer u_freerun_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .cnt_tick(cnt_tick)
    );

    function automatic int m_tick();
        return (m_stop == 0 && m_phase >= ((2 << m_sel) - 1)) ? 1 : 0;
    endfunction

    function automatic int m_ctrl();
        return (m_flag << 7) | (m_ien << 6) | (m_stop << 5) | m_sel;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin : model
        int t, ovf;
        bit cw, dw, clr, ld;
        if (!rst_n) begin
            m_cnt = 0; m_phase = 0; m_flag = 0; m_ien = 0; m_stop = 0; m_sel = 0;
        end else begin
            t   = m_tick();
            cw  = wr_en && (addr == 1'b0);
            dw  = wr_en && (addr == 1'b1);
            clr = cw && wdata[3];
            ld  = dw && (m_stop != 0);
            ovf = (t != 0 && m_cnt == 65535 && !clr && !ld) ? 1 : 0;
            if (clr || ld)        m_phase = 0;
            else if (m_stop == 0) m_phase = (t != 0) ? 0 : m_phase + 1;
            if (clr)              m_cnt = 0;
            else if (ld)          m_cnt = int'(wdata);
            else if (t != 0)      m_cnt = (m_cnt + 1) % 65536;
            if (cw && !wdata[7])  m_flag = 0;
            if (ovf != 0)         m_flag = 1;
            if (cw) begin
                m_ien  = wdata[6] ? 1 : 0;
                m_stop = wdata[5] ? 1 : 0;
                m_sel  = int'(wdata[2:0]);
            end
        end
    end

    // compare with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(cnt_tick) == m_tick(), "R2 strobe", int'(cnt_tick), m_tick());
            chk(int'(irq) == (m_flag & m_ien), "R4 irq", int'(irq), m_flag & m_ien);
            if (addr)
                chk(int'(rdata) == m_cnt, "R3 R7 R8 count read", int'(rdata), m_cnt);
            else
                chk(int'(rdata) == m_ctrl(), "R5 R6 R10 control read", int'(rdata), m_ctrl());
        end
    end

    task automatic wr_now(input bit a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0; addr = 1'b1;
    endtask

    task automatic wr(input bit a, input logic [15:0] d);
        @(posedge clk); #2;
        wr_now(a, d);
    endtask

    task automatic rd(input bit a, output int v);
        @(posedge clk); #2;
        addr = a;
        @(negedge clk);
        v = int'(rdata);
    endtask

    task automatic gap(output int g);
        do @(negedge clk); while (!cnt_tick);
        g = 0;
        do begin @(negedge clk); g++; end while (!cnt_tick);
    endtask

    task automatic first_tick(output int g, output int first_rd);
        @(negedge clk);
        first_rd = int'(rdata);
        g = 1;
        while (!cnt_tick && g < 1000) begin @(negedge clk); g++; end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int v, v0, g;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(rdata == 16'h0000, "R1 count after reset", int'(rdata), 0);
        chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
        rd(1'b0, v);
        chk(v == 0, "R1 control after reset", v, 0);

        // R2: divide periods
        gap(g);
        chk(g == 2, "R2 period sel0", g, 2);
        wr(1'b0, 16'h0002);
        gap(g); gap(g);
        chk(g == 8, "R2 period sel2", g, 8);
        wr(1'b0, 16'h0007);
        gap(g); gap(g);
        chk(g == 256, "R2 period sel7", g, 256);

        // R6: halt holds the counter
        wr(1'b0, 16'h0020);
        rd(1'b1, v0);
        repeat (20) @(posedge clk);
        rd(1'b1, v);
        chk(v == v0, "R6 halted count holds", v, v0);
        chk(cnt_tick == 1'b0, "R6 no strobe while halted", int'(cnt_tick), 0);

        // R7 load while halted, then R9 first advance after resume
        wr(1'b1, 16'hFFF0);
        rd(1'b1, v);
        chk(v == 16'hFFF0, "R7 preload accepted", v, 16'hFFF0);
        wr(1'b0, 16'h0001);
        first_tick(g, v);
        chk(g == 4, "R9 first advance after preload", g, 4);

        // R8 clear with reserved bit written, R9 restart, R10 reserved reads 0
        wr(1'b0, 16'h0019);
        first_tick(g, v);
        chk(v == 0, "R8 count zero after clear", v, 0);
        chk(g == 4, "R9 first advance after clear", g, 4);
        rd(1'b0, v);
        chk((v & 16'h0008) == 0, "R8 clear bit reads 0", v, v & 16'hFFF7);
        chk((v & 16'h0010) == 0, "R10 reserved bit reads 0", v, v & 16'hFFEF);

        // R7: write while running is ignored
        wr(1'b1, 16'h1234);
        @(negedge clk);
        chk(rdata != 16'h1234 && int'(rdata) == m_cnt, "R7 running write ignored", int'(rdata), m_cnt);

        // R3/R4: rollover with interrupt enabled
        wr(1'b0, 16'h0020);
        wr(1'b1, 16'hFFFC);
        wr(1'b0, 16'h0040);
        repeat (20) @(posedge clk);
        rd(1'b0, v);
        chk((v & 16'h0080) != 0, "R3 flag set by rollover", v, v | 16'h0080);
        chk(irq == 1'b1, "R4 irq with flag and enable", int'(irq), 1);
        rd(1'b1, v);
        chk(v < 16'h0100 && v == m_cnt, "R3 counting continues from zero", v, m_cnt);

        // R5: write 1 keeps flag, write 0 clears, write 1 cannot set
        wr(1'b0, 16'h00C0);
        rd(1'b0, v);
        chk((v & 16'h0080) != 0, "R5 write 1 keeps flag", v, v | 16'h0080);
        wr(1'b0, 16'h0040);
        rd(1'b0, v);
        chk((v & 16'h0080) == 0, "R5 write 0 clears flag", v, v & 16'hFF7F);
        chk(irq == 1'b0, "R4 irq drops with flag", int'(irq), 0);
        wr(1'b0, 16'h00C0);
        rd(1'b0, v);
        chk((v & 16'h0080) == 0, "R5 write 1 does not set flag", v, v & 16'hFF7F);

        // R5: rollover in the same cycle as a clearing write
        wr(1'b0, 16'h0060);
        wr(1'b1, 16'hFFFF);
        wr(1'b0, 16'h0040);
        for (int i = 0; i < 50; i++) begin
            if (m_tick() != 0 && m_cnt == 65535) break;
            @(posedge clk); #2;
        end
        chk(m_tick() != 0 && m_cnt == 65535, "R5 collision cycle reached", m_cnt, 65535);
        wr_now(1'b0, 16'h0040);
        rd(1'b0, v);
        chk((v & 16'h0080) != 0, "R5 rollover beats clearing write", v, v | 16'h0080);
        chk(irq == 1'b1, "R4 irq after collision", int'(irq), 1);

        repeat (5) @(posedge clk);
        summary();
    end
endmodule